// File: doc/BRIEF.md
# DRAM auto-refresh scheduler

This block sits next to the command arbiter of a DDR SDRAM controller and keeps the refresh rate of the memory. It counts clock cycles and raises one owed refresh each time the average refresh interval elapses. Owed refreshes are held in a small counter, so a refresh can wait while normal traffic uses the memory. It asks the arbiter for a slot through a request and grant pair. It fires the refresh command strobe only when every bank is precharged. After each command it blocks further commands until the refresh row cycle time has passed.

While fewer refreshes are owed than the postponement limit, the request is polite: a grant turns into a command only when the arbiter also reports that it has no normal work. When the owed count reaches the limit, the block flags the request as urgent. It then stays urgent and drains the whole backlog at the recovery spacing, whatever the traffic. The interval and recovery lengths come from the clock period in picoseconds. The interval is rounded down so that the average rate is never too slow. The recovery is rounded up so that the hold is never too short.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, ref_req, ref_urgent, ref_cmd and hold_busy are all 0.
- R2: The owed count rises by one every INTERVAL = floor(REFI_PS / CLK_PS) cycles. INTERVAL is 2080 at the defaults. The first rise takes effect in the cycle 2080 clock edges after reset release. ref_req is 1 exactly when the owed count is nonzero and hold_busy is 0.
- R3: While ref_urgent is 0, ref_cmd is 1 only in a cycle where ref_req, ref_gnt, arb_idle and banks_idle are all 1. A grant while arb_idle is 0 issues nothing.
- R4: ref_cmd is never 1 while banks_idle is 0, urgent or not.
- R5: ref_urgent becomes 1 in the cycle the owed count reaches MAX_DEBT (8). It stays 1 until the owed count returns to 0. While it is 1, ref_cmd fires on ref_req, ref_gnt and banks_idle whatever the value of arb_idle.
- R6: After a ref_cmd cycle, hold_busy is 1 and ref_req is 0 for the next RFC_CYC-1 cycles. RFC_CYC = ceil(RFC_PS / CLK_PS), which is 10 at the defaults. No two commands are closer than RFC_CYC cycles.
- R7: Each ref_cmd lowers the owed count by one, and ref_req falls once the count is 0.
- R8: When an interval ends in the same cycle that ref_cmd fires, the owed count is unchanged.
- R9: The owed count saturates at MAX_DEBT. An interval that ends while the count is at the limit and no command fires is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PS |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | 1 when every bank is precharged |
| arb_idle | input | 1 | 1 when the arbiter has no normal command pending |
| ref_gnt | input | 1 | Arbiter grants the command slot to refresh |
| ref_req | output | 1 | Refresh slot requested |
| ref_urgent | output | 1 | Request must take priority over normal traffic |
| ref_cmd | output | 1 | One-cycle auto-refresh command strobe |
| hold_busy | output | 1 | Refresh recovery in progress, no command may start |

## Verification
The assertions assume that banks_idle, arb_idle and ref_gnt are settled before each rising edge. They also assume that the arbiter may raise ref_gnt at any time, including without a request, and that a stray grant must then have no effect. The stimulus changes these inputs once per cycle, shortly after the rising edge. It moves through phases: free grants, a busy arbiter, open banks while the backlog fills, a withheld grant past saturation, and a release timed onto an interval boundary.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_PS   = 7500,
  parameter int REFI_PS  = 15_600_000,
  parameter int RFC_PS   = 75_000,
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic arb_idle,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_cmd,
  output logic hold_busy
);

  localparam int INTERVAL = REFI_PS / CLK_PS;
  localparam int RFC_CYC  = (RFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int IW       = $clog2(INTERVAL + 1);
  localparam int DW       = $clog2(MAX_DEBT + 1);
  localparam int HW       = $clog2(RFC_CYC + 1);

  logic [IW-1:0] icnt;
  logic [DW-1:0] debt, debt_nxt;
  logic [HW-1:0] hold;
  logic          due, urg_q;

  assign due        = (icnt == IW'(INTERVAL - 1));
  assign hold_busy  = (hold != '0);
  assign ref_req    = (debt != '0) && !hold_busy;
  assign ref_urgent = urg_q;
  assign ref_cmd    = ref_req && ref_gnt && banks_idle && (urg_q || arb_idle);

  always_comb begin
    debt_nxt = debt;
    if (due && !ref_cmd) begin
      if (debt != DW'(MAX_DEBT)) debt_nxt = debt + 1'b1;
    end else if (!due && ref_cmd) begin
      debt_nxt = debt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt  <= '0;
      debt  <= '0;
      urg_q <= 1'b0;
      hold  <= '0;
    end else begin
      icnt  <= due ? '0 : icnt + 1'b1;
      debt  <= debt_nxt;
      urg_q <= (debt_nxt == DW'(MAX_DEBT)) || (urg_q && debt_nxt != '0);
      if (ref_cmd)        hold <= HW'(RFC_CYC - 1);
      else if (hold_busy) hold <= hold - 1'b1;
    end
  end

  // R2: an ended interval without a command adds one owed refresh
  p_debt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !ref_cmd && debt != DW'(MAX_DEBT)) |=> (debt == $past(debt) + 1'b1));

  // R3: polite refresh waits for an idle arbiter
  p_low_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && !ref_urgent) |-> arb_idle);

  // R4: never refresh with a bank open
  p_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> banks_idle);

  // R5: urgency starts only at the limit
  p_urgent_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_urgent) |-> (debt == DW'(MAX_DEBT)));

  // R6: recovery hold follows every command
  p_hold_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> (hold_busy && !ref_cmd));

  // R7: a command alone retires one owed refresh
  p_cmd_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && !due) |=> (debt == $past(debt) - 1'b1));

  // R8: simultaneous end of interval and command cancel out
  p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && due) |=> $stable(debt));

  // R9: owed count never passes the limit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(MAX_DEBT));

endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;

  localparam int I_CYC = 2080;
  localparam int R_CYC = 10;
  localparam int LIMIT = 8;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1, arb_idle = 1'b1, ref_gnt = 1'b1;
  logic ref_req, ref_urgent, ref_cmd, hold_busy;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .arb_idle(arb_idle),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_cmd(ref_cmd), .hold_busy(hold_busy)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go(input int n);
    while (cyc != n) begin
      @(posedge clk);
      #1;
    end
  endtask

  int  md = 0, mh = 0;
  bit  murg = 1'b0, prev_cmd = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!ref_req && !ref_urgent && !ref_cmd && !hold_busy, "R1 in reset",
          {ref_req, ref_urgent, ref_cmd, hold_busy}, 0);
    end else if (!done) begin
      int  d;
      bit  ereq, ecmd;
      d = md;
      if (cyc > 0 && cyc % I_CYC == 0) d++;
      if (prev_cmd) begin
        d--;
        mh = R_CYC - 1;
      end else if (mh > 0) begin
        mh--;
      end
      if (d > LIMIT) d = LIMIT;
      md   = d;
      murg = (md == LIMIT) || (murg && md != 0);
      ereq = (md > 0) && (mh == 0);
      ecmd = ereq && ref_gnt && banks_idle && (murg || arb_idle);
      if (cyc == 0)
        chk(!ref_req && !ref_urgent && !ref_cmd && !hold_busy, "R1 after reset",
            {ref_req, ref_urgent, ref_cmd, hold_busy}, 0);
      chk(ref_req == ereq, "R2/R7 ref_req", ref_req, ereq);
      chk(ref_urgent == murg, "R5 ref_urgent", ref_urgent, murg);
      chk(hold_busy == (mh > 0), "R6 hold_busy", hold_busy, mh > 0);
      chk(ref_cmd == ecmd, "R3/R4 ref_cmd", ref_cmd, ecmd);
      if (ref_cmd) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected refresh", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, e.tag, cyc, e.cyc);
        end
      end
      prev_cmd = ref_cmd;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: free grants, one refresh per interval
    push(2080, "R2 first refresh");
    push(4160, "R2 second refresh");
    go(4170);
    // R3: arbiter busy, backlog of three waits
    arb_idle = 1'b0;
    go(10500);
    arb_idle = 1'b1;
    push(10500, "R3 release 1");
    push(10510, "R6 spacing 2");
    push(10520, "R6 spacing 3");
    go(10600);
    // R4 and R5: banks open while backlog reaches the limit
    arb_idle   = 1'b0;
    banks_idle = 1'b0;
    go(27100);
    banks_idle = 1'b1;
    for (int k = 0; k < 8; k++) push(27100 + k * R_CYC, "R5 urgent burst");
    go(27200);
    // R9: grant withheld past saturation, only eight issue
    ref_gnt = 1'b0;
    go(48000);
    ref_gnt = 1'b1;
    for (int k = 0; k < 8; k++) push(48000 + k * R_CYC, "R9 saturated burst");
    // R8: release lands on an interval boundary
    go(54079);
    arb_idle = 1'b1;
    push(54079, "R8 on boundary");
    push(54089, "R8 second");
    push(54099, "R8 third");
    go(54300);
    done = 1'b1;
    chk(q.size() == 0, "R7 missing refreshes", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule